// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the driver-enable (direction) pin of a half-duplex RS-485 transceiver that sits behind a UART transmitter. When automatic mode is on, the pin stays inactive while the transmitter has nothing to send, so the transceiver listens for the remote station. The host only has to write bytes into the transmit FIFO. The block sees the FIFO go non-empty and asserts the pin. It then waits a programmable number of baud ticks before it grants the transmitter permission to send its first start bit. The pin is released only after the stop bit of the last queued character has finished and the FIFO is still empty.

A polarity control selects the active level of the pin. When automatic mode is off, the pin passes the software RTS value through unchanged, and the transmitter is always allowed to start. The enable and polarity settings are sampled only while the transmit path is idle: the FIFO is empty, the shifter is idle and no direction cycle is in progress. A change made in the middle of a transmission therefore waits until the line has been handed back.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: In the cycles after reset, automatic mode is off: `dirPin` equals `swRts` and `txStartOk` is 1.
- R2: With automatic mode on and the transmit path idle, `dirPin` sits at its inactive level and `txStartOk` is 0. With normal polarity the inactive level is 0.
- R3: With automatic mode on and the block idle, a cycle in which `txFifoEmpty` is low makes `dirPin` active from the next cycle onward.
- R4: After `dirPin` becomes active, `txStartOk` stays 0 until exactly `LEAD_TICKS` cycles with `baudTick` high have been sampled. It goes to 1 in the cycle after the last of those ticks.
- R5: A cycle in which `stopDone` is high and `txFifoEmpty` is high ends the direction cycle. In the next cycle `dirPin` returns to its inactive level and `txStartOk` returns to 0.
- R6: While a direction cycle is active, `dirPin` stays active and `txStartOk` stays 1, with no glitch, across every `stopDone` that arrives while the FIFO is not empty.
- R7: When polarity is inverted (`invPol`=1 when latched), the active level of `dirPin` is 0 and the inactive level is 1.
- R8: With automatic mode off, `dirPin` follows `swRts` in the same cycle and `txStartOk` is 1, whatever the FIFO and shifter do.
- R9: `autoEn` and `invPol` are latched only in cycles where the block is idle, `txFifoEmpty` is 1 and `shiftBusy` is 0. Changes at any other time have no effect until such a cycle occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle baud tick strobe |
| txFifoEmpty | input | 1 | Transmit FIFO is empty |
| shiftBusy | input | 1 | Serial shifter is sending a character |
| stopDone | input | 1 | One-cycle strobe at the end of a stop bit |
| autoEn | input | 1 | Automatic direction control enable |
| invPol | input | 1 | Inverts the active level of the direction pin |
| swRts | input | 1 | Software RTS value used when automatic mode is off |
| dirPin | output | 1 | Transceiver direction / driver-enable pin |
| txStartOk | output | 1 | Permission for the transmitter to start a character |

## Verification
The assertions assume that the transmitter starts a character only while `txStartOk` is high. They also assume that `stopDone` pulses only at the end of a character the shifter is sending, and that `txFifoEmpty` changes only because the host pushes bytes or the shifter pops them. The bench meets these assumptions with a behavioural FIFO counter and shifter. The shifter takes a byte only when permission is high and raises `stopDone` once, in the last cycle of each frame. Host writes are timed against this model, including a write that lands during the final frame, and configuration changes are made both while idle and during a transfer.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_SEND = 2'd2
  } dirState_t;

  typedef struct packed {
    logic cfgLoad;   // sample enable / polarity settings
    logic cntClr;    // clear the lead-time counter
    logic cntStep;   // count one baud tick of lead time
    logic dirOn;     // direction cycle active
    logic startOk;   // transmitter may send
  } dirStrobes_t;

endpackage

// File: rtl/rs485_dir_ctrl_fsm.sv
module rs485_dir_ctrl_fsm
  import rs485_dir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        baudTick,
  input  logic        txFifoEmpty,
  input  logic        shiftBusy,
  input  logic        stopDone,
  input  logic        cfgEn,
  input  logic        leadDone,
  output dirStrobes_t strobes
);

  dirState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (cfgEn && !txFifoEmpty) stateNext = ST_LEAD;
      ST_LEAD: if (leadDone) stateNext = ST_SEND;
      ST_SEND: if (stopDone && txFifoEmpty) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.cfgLoad = (state == ST_IDLE) && txFifoEmpty && !shiftBusy;
    strobes.cntClr  = (state == ST_IDLE);
    strobes.cntStep = (state == ST_LEAD) && baudTick;
    strobes.dirOn   = (state != ST_IDLE);
    strobes.startOk = (state == ST_SEND);
  end

  // R3
  dir_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cfgEn && !txFifoEmpty) |=> strobes.dirOn);

  // R5
  dir_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && stopDone && txFifoEmpty) |=> !strobes.dirOn);

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dirOn && !(stopDone && txFifoEmpty)) |=> strobes.dirOn);

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(cfgEn));

endmodule

// File: rtl/rs485_dir_datapath.sv
module rs485_dir_datapath
  import rs485_dir_pkg::*;
#(
  parameter int LEAD_TICKS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  dirStrobes_t strobes,
  input  logic        autoEn,
  input  logic        invPol,
  input  logic        swRts,
  output logic        cfgEn,
  output logic        leadDone,
  output logic        dirPin,
  output logic        txStartOk
);

  localparam int CNT_W = (LEAD_TICKS > 1) ? $clog2(LEAD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEAD_TICKS - 1);

  logic             cfgInv;
  logic [CNT_W-1:0] leadCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn  <= 1'b0;
      cfgInv <= 1'b0;
    end else if (strobes.cfgLoad) begin
      cfgEn  <= autoEn;
      cfgInv <= invPol;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                leadCnt <= '0;
    else if (strobes.cntClr)  leadCnt <= '0;
    else if (strobes.cntStep) leadCnt <= leadCnt + 1'b1;
  end

  assign leadDone  = strobes.cntStep && (leadCnt == CNT_LAST);
  assign dirPin    = cfgEn ? (strobes.dirOn ^ cfgInv) : swRts;
  assign txStartOk = cfgEn ? strobes.startOk : 1'b1;

  // R4
  lead_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadDone |-> (strobes.dirOn && !strobes.startOk));

  // R4
  start_after_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && $rose(strobes.startOk)) |-> $past(leadDone));

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int LEAD_TICKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic baudTick,
  input  logic txFifoEmpty,
  input  logic shiftBusy,
  input  logic stopDone,
  input  logic autoEn,
  input  logic invPol,
  input  logic swRts,
  output logic dirPin,
  output logic txStartOk
);

  dirStrobes_t strobes;
  logic        cfgEn;
  logic        leadDone;

  rs485_dir_ctrl_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .baudTick    (baudTick),
    .txFifoEmpty (txFifoEmpty),
    .shiftBusy   (shiftBusy),
    .stopDone    (stopDone),
    .cfgEn       (cfgEn),
    .leadDone    (leadDone),
    .strobes     (strobes)
  );

  rs485_dir_datapath #(.LEAD_TICKS(LEAD_TICKS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .autoEn    (autoEn),
    .invPol    (invPol),
    .swRts     (swRts),
    .cfgEn     (cfgEn),
    .leadDone  (leadDone),
    .dirPin    (dirPin),
    .txStartOk (txStartOk)
  );

endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;

  localparam int LEAD  = 16;
  localparam int FRAME = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baudTick = 1'b0, txFifoEmpty = 1'b1, shiftBusy = 1'b0, stopDone = 1'b0;
  logic autoEn = 1'b0, invPol = 1'b0, swRts = 1'b0;
  logic dirPin, txStartOk;

  always #5 clk = ~clk;

  rs485_dir_ctrl #(.LEAD_TICKS(LEAD)) u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .txFifoEmpty(txFifoEmpty),
    .shiftBusy(shiftBusy), .stopDone(stopDone), .autoEn(autoEn),
    .invPol(invPol), .swRts(swRts), .dirPin(dirPin), .txStartOk(txStartOk)
  );

  int checks = 0, fails = 0, cyc = 0;
  int fifoCnt = 0, busyCnt = 0, pushReq = 0;
  string curReq = "R1";

  // behavioural reference: phase 0 listen, 1 lead-in, 2 talking
  int  mPhase = 0, mTicks = 0;
  bit  mEn = 0, mInv = 0;
  bit  prevOk = 1;
  int  leadSeen = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mTicks = 0; mEn = 0; mInv = 0;
    end else begin
      if (mPhase == 0) begin
        if (mEn && !txFifoEmpty) begin mPhase = 1; mTicks = 0; end
        else if (txFifoEmpty && !shiftBusy) begin mEn = autoEn; mInv = invPol; end
      end else if (mPhase == 1) begin
        if (baudTick) mTicks++;
        if (mTicks == LEAD) mPhase = 2;
      end else if (stopDone && txFifoEmpty) mPhase = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // one cycle: compare at negedge, then drive the next inputs
  task automatic step();
    bit expPin, expOk, inLead;
    @(negedge clk);
    cyc++;
    if (rstN) begin
      expPin = mEn ? ((mPhase != 0) ^ mInv) : swRts;
      expOk  = mEn ? (mPhase == 2) : 1'b1;
      chk(dirPin == expPin, {curReq, " dirPin"}, dirPin, expPin);
      chk(txStartOk == expOk, {curReq, " txStartOk"}, txStartOk, expOk);
      // R4: count baud ticks spent between direction assert and permission
      if (mEn && txStartOk && !prevOk) begin
        chk(leadSeen == LEAD, "R4 lead ticks", leadSeen, LEAD);
        leadSeen = 0;
      end
      inLead = mEn && (mPhase == 1);
      prevOk = txStartOk;
    end else inLead = 0;
    baudTick = (cyc % 4 == 3);
    if (inLead && baudTick) leadSeen++;
    if (busyCnt > 0) begin
      shiftBusy = 1; stopDone = (busyCnt == 1); busyCnt--;
    end else if (txStartOk && fifoCnt > 0) begin
      fifoCnt--; busyCnt = FRAME - 1; shiftBusy = 1; stopDone = 0;
    end else begin
      shiftBusy = 0; stopDone = 0;
    end
    fifoCnt += pushReq; pushReq = 0;
    txFifoEmpty = (fifoCnt == 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain();
    int guard = 0;
    while ((fifoCnt > 0 || busyCnt > 0 || mPhase != 0) && guard < 20000) begin
      step(); guard++;
    end
    run(3);
  endtask

  task automatic peek(input bit expPin, input bit expOk, input string req);
    @(posedge clk); #2;
    chk(dirPin == expPin, {req, " direct pin"}, dirPin, expPin);
    chk(txStartOk == expOk, {req, " direct ok"}, txStartOk, expOk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset and pass-through defaults
    run(3);
    rstN = 1'b1;
    swRts = 1'b1; step(); peek(1'b1, 1'b1, "R1");
    swRts = 1'b0; step(); peek(1'b0, 1'b1, "R1");

    // R8: automatic mode off, traffic flows, pin follows software
    curReq = "R8";
    pushReq = 2; step();
    for (int i = 0; i < 40; i++) begin swRts = i[2]; step(); end
    drain();

    // R2: enable while idle, pin listens
    curReq = "R2";
    autoEn = 1'b1; run(4);
    peek(1'b0, 1'b0, "R2");

    // R3, R4, R5: single byte
    curReq = "R3";
    pushReq = 1; step();
    peek(1'b1, 1'b0, "R3");
    curReq = "R5";
    drain();
    peek(1'b0, 1'b0, "R5");

    // R6: burst with a late write during the final frame
    curReq = "R6";
    pushReq = 3; step();
    while (!(fifoCnt == 0 && busyCnt == 10)) step();
    pushReq = 1; step();
    drain();

    // R9: config changes during a transfer are held off
    curReq = "R9";
    pushReq = 2; step(); run(30);
    autoEn = 1'b0; invPol = 1'b1; run(5);
    peek(1'b1, txStartOk, "R9");
    drain();
    peek(1'b1, 1'b1, "R9 inverted-off idle");
    swRts = 1'b0; step(); peek(1'b0, 1'b1, "R9 disabled after idle");

    // R7: inverted polarity in automatic mode
    curReq = "R7";
    autoEn = 1'b1; invPol = 1'b1; run(4);
    peek(1'b1, 1'b0, "R7 idle");
    pushReq = 2; step();
    peek(1'b0, 1'b0, "R7 active");
    drain();
    peek(1'b1, 1'b0, "R7 released");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule